// File: doc/BRIEF.md
# Power Management Control/Status Register Bank

This block holds the power-management registers of a configuration-space function, packed into one 32-bit configuration dword. The low half is a control/status word. It carries a writable power-state field, a PME enable bit, a data-select field and a data-scale field. Byte 2 is a bridge-extension byte that always reads as zero. Byte 3 is a data byte. Configuration software writes the dword under per-byte enables and reads it back one cycle after a read strobe.

The data byte and the scale field are not stored in the bank. They are looked up from a set of preloaded entries, using the data-select field as the index. The preloaded entries stand in for values that a non-volatile loader delivers. Select values beyond the last entry read as zero.

The bank uses two reset domains. A power-on reset clears everything. Three function-level resets (hardware reset, software reset and a stop control) return the power state and the select field to their defaults. None of the three touches the PME enable bit, so that bit is sticky. The current power state is also driven out on status pins, so neighbouring logic can tell full power from the low-power states.

Top module: `pm_cfg_regs`

## Requirements
- R1: Bits 1:0 hold the power state, encoded 00 = D0, 01 = D1, 10 = D2, 11 = D3. A write with byte enable 0 set loads wdata[1:0], and a later read returns it.
- R2: A write with byte enable 0 clear leaves the power state unchanged.
- R3: Bits 7:2 and bit 15 of the dword always read 0, and writes to them are ignored.
- R4: Bit 8 is PME enable. A write with byte enable 1 set loads wdata[8].
- R5: Only power-on reset clears PME enable. Hardware reset, software reset and stop leave it unchanged.
- R6: A single-cycle pulse on hardware reset, software reset or stop returns the power state to D0 and the select field to 0.
- R7: Bits 12:9 form the data-select field, written under byte enable 1. Bits 31:24 return the data value of the preloaded entry it selects, and bits 14:13 return that entry's scale. Writes to bits 14:13 and 31:24 are ignored.
- R8: When the select value is not below NUM_ENTRIES, bits 31:24 and 14:13 read 0.
- R9: Bits 23:16 (the bridge-extension byte) always read 00h, whatever is written to them.
- R10: After power-on reset, every field reads 0 and cfg_rdata is 0.
- R11: pwr_state_o shows the current power state, pme_en_o shows PME enable, and low_power_o is 1 exactly when the state is not D0.
- R12: cfg_rdata updates at the clock edge where cfg_rd is high and holds its value at every other edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por | input | 1 | Power-on reset, synchronous, active high; clears every field |
| hw_rst | input | 1 | Hardware function reset, synchronous, active high |
| sw_rst | input | 1 | Software function reset, synchronous, active high |
| stop | input | 1 | Stop control; acts as a function reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_rd | input | 1 | Configuration read strobe |
| cfg_be | input | 4 | Byte enables for a write |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Registered read data |
| preload_data | input | NUM_ENTRIES*8 | Preloaded data values; entry k is at bits [8k+7:8k] |
| preload_scale | input | NUM_ENTRIES*2 | Preloaded scale values; entry k is at bits [2k+1:2k] |
| pwr_state_o | output | 2 | Current power state |
| pme_en_o | output | 1 | Current PME enable |
| low_power_o | output | 1 | 1 when the power state is D1, D2 or D3 |

## Verification
The assertions assume that the reset inputs are synchronous and that the preloaded inputs hold steady between a select write and the read that follows it. They also assume that read and write strobes may be driven in any cycle, with no hold-off after a function reset. The bench drives every strobe and reset on the falling clock edge for exactly one cycle and sets the preloaded values once, before reset is released. It never reads in the same cycle as a write, so each read shows only completed writes.

// File: rtl/pm_cfg_pkg.sv
package pm_cfg_pkg;

  localparam int PSTATE_W = 2;
  localparam int DATA_W   = 8;
  localparam int SCALE_W  = 2;

  typedef enum logic [PSTATE_W-1:0] {
    PS_D0 = 2'b00,
    PS_D1 = 2'b01,
    PS_D2 = 2'b10,
    PS_D3 = 2'b11
  } pstate_e;

  // bit positions inside the configuration dword
  localparam int POS_PSTATE = 0;
  localparam int POS_PME    = 8;
  localparam int POS_SEL    = 9;
  localparam int POS_SCALE  = 13;
  localparam int POS_BRIDGE = 16;
  localparam int POS_DATA   = 24;

endpackage

// File: rtl/pm_state_reg.sv
module pm_state_reg
  import pm_cfg_pkg::*;
#(
  parameter int SEL_W = 4
) (
  input  logic             clk,
  input  logic             por,
  input  logic             func_rst,
  input  logic             wr_lo,
  input  logic             wr_hi,
  input  logic [1:0]       wd_pstate,
  input  logic [SEL_W-1:0] wd_sel,
  output pstate_e          pstate_q,
  output logic [SEL_W-1:0] sel_q
);

  always_ff @(posedge clk) begin
    if (por || func_rst) begin
      pstate_q <= PS_D0;
      sel_q    <= '0;
    end else begin
      if (wr_lo) pstate_q <= pstate_e'(wd_pstate);
      if (wr_hi) sel_q    <= wd_sel;
    end
  end

  // R6: any function reset lands in D0 with select cleared
  p_func_rst_d0_r6: assert property (@(posedge clk) disable iff (por)
    func_rst |=> (pstate_q == PS_D0) && (sel_q == '0));

  // R2: without a low-byte write the state does not move
  p_be0_hold_r2: assert property (@(posedge clk) disable iff (por)
    (!wr_lo && !func_rst) |=> $stable(pstate_q));

endmodule

// File: rtl/pm_sticky_reg.sv
module pm_sticky_reg (
  input  logic clk,
  input  logic por,
  input  logic wr_en,
  input  logic wd,
  output logic q
);

  always_ff @(posedge clk) begin
    if (por)        q <= 1'b0;
    else if (wr_en) q <= wd;
  end

  // R5: only a write may change the bit once power-on reset is gone
  p_sticky_hold_r5: assert property (@(posedge clk) disable iff (por)
    !wr_en |=> $stable(q));

endmodule

// File: rtl/pm_data_mux.sv
module pm_data_mux #(
  parameter int NUM_ENTRIES = 8,
  parameter int SEL_W       = 4,
  parameter int DATA_W      = 8,
  parameter int SCALE_W     = 2
) (
  input  logic [SEL_W-1:0]               sel,
  input  logic [NUM_ENTRIES*DATA_W-1:0]  preload_data,
  input  logic [NUM_ENTRIES*SCALE_W-1:0] preload_scale,
  output logic [DATA_W-1:0]              data_o,
  output logic [SCALE_W-1:0]             scale_o
);

  logic [NUM_ENTRIES-1:0] hit;

  for (genvar k = 0; k < NUM_ENTRIES; k++) begin : g_hit
    assign hit[k] = (sel == SEL_W'(k));
  end

  always_comb begin
    data_o  = '0;
    scale_o = '0;
    for (int k = 0; k < NUM_ENTRIES; k++) begin
      if (hit[k]) begin
        data_o  = preload_data[k*DATA_W +: DATA_W];
        scale_o = preload_scale[k*SCALE_W +: SCALE_W];
      end
    end
  end

  always_comb begin
    a_hit_onehot_r7: assert ($onehot0(hit));
  end

endmodule

// File: rtl/pm_cfg_regs.sv
module pm_cfg_regs
  import pm_cfg_pkg::*;
#(
  parameter int NUM_ENTRIES = 8,
  parameter int SEL_W       = 4
) (
  input  logic                           clk,
  input  logic                           por,
  input  logic                           hw_rst,
  input  logic                           sw_rst,
  input  logic                           stop,
  input  logic                           cfg_wr,
  input  logic                           cfg_rd,
  input  logic [3:0]                     cfg_be,
  input  logic [31:0]                    cfg_wdata,
  output logic [31:0]                    cfg_rdata,
  input  logic [NUM_ENTRIES*DATA_W-1:0]  preload_data,
  input  logic [NUM_ENTRIES*SCALE_W-1:0] preload_scale,
  output logic [PSTATE_W-1:0]            pwr_state_o,
  output logic                           pme_en_o,
  output logic                           low_power_o
);

  localparam int SEL_MAX = 1 << SEL_W;

  initial begin
    if (NUM_ENTRIES > SEL_MAX) $error("NUM_ENTRIES exceeds select range");
    if (SEL_W != POS_SCALE - POS_SEL) $error("select width must fill its field");
  end

  logic                func_rst;
  logic                wr_lo;
  logic                wr_hi;
  pstate_e             pstate_q;
  logic [SEL_W-1:0]    sel_q;
  logic                pme_q;
  logic [DATA_W-1:0]   sel_data;
  logic [SCALE_W-1:0]  sel_scale;
  logic [31:0]         rd_word;
  logic                unused_wdata_bits;

  assign func_rst = hw_rst | sw_rst | stop;
  assign wr_lo    = cfg_wr & cfg_be[0];
  assign wr_hi    = cfg_wr & cfg_be[1];
  assign unused_wdata_bits = ^{cfg_wdata[31:POS_SCALE], cfg_wdata[7:2], cfg_be[3:2]};

  pm_state_reg #(.SEL_W(SEL_W)) u_state (
    .clk       (clk),
    .por       (por),
    .func_rst  (func_rst),
    .wr_lo     (wr_lo),
    .wr_hi     (wr_hi),
    .wd_pstate (cfg_wdata[POS_PSTATE +: PSTATE_W]),
    .wd_sel    (cfg_wdata[POS_SEL +: SEL_W]),
    .pstate_q  (pstate_q),
    .sel_q     (sel_q)
  );

  pm_sticky_reg u_pme (
    .clk   (clk),
    .por   (por),
    .wr_en (wr_hi),
    .wd    (cfg_wdata[POS_PME]),
    .q     (pme_q)
  );

  pm_data_mux #(
    .NUM_ENTRIES (NUM_ENTRIES),
    .SEL_W       (SEL_W),
    .DATA_W      (DATA_W),
    .SCALE_W     (SCALE_W)
  ) u_mux (
    .sel           (sel_q),
    .preload_data  (preload_data),
    .preload_scale (preload_scale),
    .data_o        (sel_data),
    .scale_o       (sel_scale)
  );

  always_comb begin
    rd_word = '0;
    rd_word[POS_PSTATE +: PSTATE_W] = pstate_q;
    rd_word[POS_PME]                = pme_q;
    rd_word[POS_SEL +: SEL_W]       = sel_q;
    rd_word[POS_SCALE +: SCALE_W]   = sel_scale;
    rd_word[POS_BRIDGE +: 8]        = 8'h00;
    rd_word[POS_DATA +: DATA_W]     = sel_data;
  end

  always_ff @(posedge clk) begin
    if (por)         cfg_rdata <= '0;
    else if (cfg_rd) cfg_rdata <= rd_word;
  end

  assign pwr_state_o = pstate_q;
  assign pme_en_o    = pme_q;
  assign low_power_o = (pstate_q != PS_D0);

  // R3 / R9: reserved bits and bridge byte read zero
  p_rsvd_zero_r3: assert property (@(posedge clk) disable iff (por)
    cfg_rd |=> (cfg_rdata[7:2] == '0) && !cfg_rdata[15] && (cfg_rdata[23:16] == 8'h00));

  // R12: read data holds without a read strobe
  p_rd_hold_r12: assert property (@(posedge clk) disable iff (por)
    !cfg_rd |=> $stable(cfg_rdata));

  // R4: read data bit 8 mirrors the sticky register sampled at the read
  p_rd_pme_r4: assert property (@(posedge clk) disable iff (por)
    cfg_rd |=> cfg_rdata[POS_PME] == $past(pme_q));

  // R8: an out-of-range select reads zero data and scale
  p_oob_zero_r8: assert property (@(posedge clk) disable iff (por)
    (cfg_rd && (int'(sel_q) >= NUM_ENTRIES)) |=>
      (cfg_rdata[31:24] == '0) && (cfg_rdata[14:13] == '0));

  // R1: a read returns the state register sampled at the read
  p_rd_state_r1: assert property (@(posedge clk) disable iff (por)
    cfg_rd |=> cfg_rdata[1:0] == $past(pwr_state_o));

endmodule

// File: tb/pm_cfg_regs_test.sv
module pm_cfg_regs_test;

  localparam int CLK_PERIOD = 10;
  localparam int N          = 8;
  localparam int SW         = 4;

  logic              clk = 1'b0;
  logic              por = 1'b1;
  logic              hw_rst = 1'b0;
  logic              sw_rst = 1'b0;
  logic              stop = 1'b0;
  logic              cfg_wr = 1'b0;
  logic              cfg_rd = 1'b0;
  logic [3:0]        cfg_be = '0;
  logic [31:0]       cfg_wdata = '0;
  logic [31:0]       cfg_rdata;
  logic [N*8-1:0]    preload_data;
  logic [N*2-1:0]    preload_scale;
  logic [1:0]        pwr_state_o;
  logic              pme_en_o;
  logic              low_power_o;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pm_cfg_regs #(.NUM_ENTRIES(N), .SEL_W(SW)) uut (
    .clk           (clk),
    .por           (por),
    .hw_rst        (hw_rst),
    .sw_rst        (sw_rst),
    .stop          (stop),
    .cfg_wr        (cfg_wr),
    .cfg_rd        (cfg_rd),
    .cfg_be        (cfg_be),
    .cfg_wdata     (cfg_wdata),
    .cfg_rdata     (cfg_rdata),
    .preload_data  (preload_data),
    .preload_scale (preload_scale),
    .pwr_state_o   (pwr_state_o),
    .pme_en_o      (pme_en_o),
    .low_power_o   (low_power_o)
  );

  function automatic logic [7:0] pre_d(int k);
    logic [7:0] kk = 8'(k);
    return 8'hA0 ^ (kk * 8'h13);
  endfunction

  function automatic logic [1:0] pre_s(int k);
    return 2'(k) ^ 2'b01;
  endfunction

  // expected dword from the field values, per R1 R3 R4 R7 R8 R9
  function automatic logic [31:0] exp_word(logic [1:0] p, logic e, logic [3:0] s);
    logic [7:0] d  = (int'(s) < N) ? pre_d(int'(s)) : 8'h00;
    logic [1:0] sc = (int'(s) < N) ? pre_s(int'(s)) : 2'b00;
    return {d, 8'h00, 1'b0, sc, s, e, 6'b0, p};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_write(logic [3:0] be, logic [31:0] wd);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_be = be; cfg_wdata = wd;
    @(negedge clk);
    cfg_wr = 1'b0; cfg_be = '0; cfg_wdata = '0;
  endtask

  task automatic do_read(output logic [31:0] rd);
    @(negedge clk);
    cfg_rd = 1'b1;
    @(negedge clk);
    cfg_rd = 1'b0;
    rd = cfg_rdata;
  endtask

  task automatic pulse(int which);
    @(negedge clk);
    case (which)
      0: hw_rst = 1'b1;
      1: sw_rst = 1'b1;
      2: stop   = 1'b1;
      default: por = 1'b1;
    endcase
    @(negedge clk);
    hw_rst = 1'b0; sw_rst = 1'b0; stop = 1'b0; por = 1'b0;
  endtask

  typedef struct packed {
    logic [3:0]  be;
    logic [31:0] wd;
    logic [1:0]  pwr;
    logic        pme;
    logic [3:0]  sel;
  } vec_t;

  localparam vec_t VEC [9] = '{
    '{4'h1, 32'h0000_0003, 2'd3, 1'b0, 4'd0},   // R1 D3
    '{4'h1, 32'h0000_00FE, 2'd2, 1'b0, 4'd0},   // R1 R3 reserved ignored
    '{4'h2, 32'h0000_0101, 2'd2, 1'b1, 4'd0},   // R2 R4
    '{4'h3, 32'h0000_0A01, 2'd1, 1'b0, 4'd5},   // R1 R7
    '{4'hF, 32'hFFFF_6301, 2'd1, 1'b1, 4'd1},   // R7 R9 scale/data/bridge ignored
    '{4'h2, 32'h0000_1E00, 2'd1, 1'b0, 4'd15},  // R8
    '{4'h2, 32'h0000_0F00, 2'd1, 1'b1, 4'd7},   // R7 last entry
    '{4'h2, 32'h0000_1000, 2'd1, 1'b0, 4'd8},   // R8 first out of range
    '{4'h1, 32'h0000_0000, 2'd0, 1'b0, 4'd8}    // R1 D0
  };

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    for (int k = 0; k < N; k++) begin
      preload_data[k*8 +: 8]  = pre_d(k);
      preload_scale[k*2 +: 2] = pre_s(k);
    end
    repeat (3) @(negedge clk);
    por = 1'b0;

    // R10: reset state
    check("R10 rdata after por", cfg_rdata, 32'h0);
    do_read(rd);
    check("R10 fields after por", rd, exp_word(2'd0, 1'b0, 4'd0));

    // vector walk
    for (int i = 0; i < 9; i++) begin
      do_write(VEC[i].be, VEC[i].wd);
      do_read(rd);
      check("R1 R2 R3 R4 R7 R8 R9 vector", rd, exp_word(VEC[i].pwr, VEC[i].pme, VEC[i].sel));
      check("R11 status", {29'b0, pwr_state_o, pme_en_o},
            {29'b0, VEC[i].pwr, VEC[i].pme});
      check("R11 low_power", {31'b0, low_power_o}, {31'b0, VEC[i].pwr != 2'd0});
    end

    // R12: rdata holds without a read
    do_write(4'h1, 32'h0000_0002);
    check("R12 hold", cfg_rdata, exp_word(2'd0, 1'b0, 4'd8));
    do_read(rd);
    check("R12 update", rd, exp_word(2'd2, 1'b0, 4'd8));

    // R5 R6: each function reset
    for (int w = 0; w < 3; w++) begin
      do_write(4'h3, 32'h0000_0703);  // pwr 3, pme 1, sel 3
      do_read(rd);
      check("R7 setup", rd, exp_word(2'd3, 1'b1, 4'd3));
      pulse(w);
      do_read(rd);
      check("R5 R6 func reset", rd, exp_word(2'd0, 1'b1, 4'd3 & 4'd0));
      check("R5 pme_en_o", {31'b0, pme_en_o}, 32'd1);
    end

    // R10 R5: power-on reset clears sticky bit
    do_write(4'h3, 32'h0000_0703);
    pulse(3);
    check("R10 rdata cleared", cfg_rdata, 32'h0);
    check("R5 pme cleared by por", {31'b0, pme_en_o}, 32'd0);
    do_read(rd);
    check("R10 fields cleared", rd, exp_word(2'd0, 1'b0, 4'd0));

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule